// File: doc/BRIEF.md
# CSR Access Permission Checker

This block sits next to a processor's control-register file and decides, in the same cycle, whether the register access presented to it may go ahead. It sees a 12-bit register address, separate read and write requests, the current privilege level, a debug-mode flag and a per-address "exists" indication from the register file. Access rights are decoded from fixed fields of the address alone, so no table of rights is stored.

A refused access raises a combinational illegal flag, and a registered one-cycle exception pulse follows on the next clock for the trap logic. The read and write strobes forwarded to the register file are gated by the decision, so a refused access never changes stored state. Privilege field `10` is reserved and always refused. One 16-address page, `0x7B0`..`0x7BF`, is open only in debug mode, even to machine level.

Top module: `csr_access_guard`

## Requirements
- R1: When neither `acc_rd` nor `acc_wr` is high, `illegal` is 0 and both forwarded strobes are 0, whatever the other inputs are.
- R2: Address bits [11:10] = `11` mark a read-only register. Any access with `acc_wr` = 1 to such an address is illegal. A read alone (`acc_rd` = 1, `acc_wr` = 0) is never refused on this ground.
- R3: Address bits [9:8] give the lowest level allowed, and `cur_priv` uses the same encoding: `00` user, `01` supervisor, `11` machine. An access is illegal when `cur_priv` is numerically below the field. Higher levels may reach lower-level registers.
- R4: An address whose bits [9:8] = `10` (reserved level) is illegal for every access.
- R5: An access with `csr_exists` = 0 is illegal.
- R6: Addresses `0x7B0`..`0x7BF` are illegal when `dbg_mode` = 0, at any privilege level. When `dbg_mode` = 1 the check uses machine level (`11`) as the privilege, whatever `cur_priv` holds.
- R7: Addresses `0x7A0`..`0x7AF` are legal for machine-level read and write when the register exists.
- R8: `rf_rd` = `acc_rd` and not `illegal`; `rf_wr` = `acc_wr` and not `illegal`; `rf_addr` always equals `acc_addr`.
- R9: `exc_pulse` is registered. It is 1 in the cycle after each cycle in which `illegal` was 1, and 0 after a cycle with no illegal access. A synchronous reset (`rst` = 1 at a rising edge) clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_addr | input | 12 | Register address of the access |
| acc_rd | input | 1 | Read requested |
| acc_wr | input | 1 | Write requested |
| cur_priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| dbg_mode | input | 1 | Core is in debug mode |
| csr_exists | input | 1 | Addressed register is implemented |
| illegal | output | 1 | Access refused, same cycle |
| exc_pulse | output | 1 | Registered exception pulse, one cycle after a refused access |
| rf_addr | output | 12 | Address forwarded to the register file |
| rf_rd | output | 1 | Gated read strobe |
| rf_wr | output | 1 | Gated write strobe |

## Verification
The bench targets the read-only region with a plain read, a plain write and a combined read-and-write. A design that keyed on the read strobe would refuse legitimate counter reads, and one that ignored a combined request would let a swap write a read-only register. It walks the privilege boundary from both sides, including the reserved level and a machine-level access to a user register. A reversed comparison or a missing check of the reserved value shows up there. It also separates the two debug pages: machine level outside debug mode must reach the trigger page but not the debug-only page, and debug mode must open that page even from user privilege. It checks that an unimplemented register blocks the write strobe, that an idle cycle stays quiet, and that the exception pulse lasts exactly one cycle and is cleared by reset.

// File: rtl/csr_access_guard.sv
module csr_access_guard #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-5:0] DBG_PAGE = 'h7B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [1:0]        cur_priv,
  input  logic              dbg_mode,
  input  logic              csr_exists,
  output logic              illegal,
  output logic              exc_pulse,
  output logic [ADDR_W-1:0] rf_addr,
  output logic              rf_rd,
  output logic              rf_wr
);
  localparam int RO_HI = ADDR_W - 1;
  localparam int RO_LO = ADDR_W - 2;
  localparam int LV_HI = ADDR_W - 3;
  localparam int LV_LO = ADDR_W - 4;

  logic       active;
  logic       ro_space;
  logic [1:0] need_lvl;
  logic [1:0] eff_priv;
  logic       dbg_only;
  logic       bad_ro, bad_lvl, bad_rsv, bad_dbg, bad_missing;

  assign active   = acc_rd | acc_wr;
  assign ro_space = (acc_addr[RO_HI:RO_LO] == 2'b11);
  assign need_lvl = acc_addr[LV_HI:LV_LO];
  assign eff_priv = dbg_mode ? 2'b11 : cur_priv;
  assign dbg_only = (acc_addr[ADDR_W-1:4] == DBG_PAGE);

  assign bad_ro      = ro_space & acc_wr;
  assign bad_rsv     = (need_lvl == 2'b10);
  assign bad_lvl     = (eff_priv < need_lvl);
  assign bad_dbg     = dbg_only & ~dbg_mode;
  assign bad_missing = ~csr_exists;

  assign illegal = active & (bad_ro | bad_rsv | bad_lvl | bad_dbg | bad_missing);

  assign rf_addr = acc_addr;
  assign rf_rd   = acc_rd & ~illegal;
  assign rf_wr   = acc_wr & ~illegal;

  always_ff @(posedge clk) begin
    if (rst) exc_pulse <= 1'b0;
    else     exc_pulse <= illegal;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd || acc_wr) |-> !illegal && !rf_rd && !rf_wr);

  // R2
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    acc_wr && acc_addr[RO_HI:RO_LO] == 2'b11 |-> illegal);

  // R3
  low_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) && !dbg_mode && cur_priv < acc_addr[LV_HI:LV_LO] |-> illegal);

  // R6
  dbg_page_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || acc_wr) && !dbg_mode && acc_addr[ADDR_W-1:4] == DBG_PAGE |-> illegal);

  // R8
  gated_wr_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !rf_wr && !rf_rd);

  // R9
  exc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> exc_pulse);

  // R9
  exc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !illegal |=> !exc_pulse);
endmodule

// File: tb/csr_access_guard_tb.sv
module csr_access_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] acc_addr = '0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0, dbg_mode = 1'b0, csr_exists = 1'b1;
  logic [1:0]  cur_priv = 2'b00;
  logic        illegal, exc_pulse, rf_rd, rf_wr;
  logic [11:0] rf_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  csr_access_guard u_dut (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .cur_priv(cur_priv), .dbg_mode(dbg_mode), .csr_exists(csr_exists),
    .illegal(illegal), .exc_pulse(exc_pulse), .rf_addr(rf_addr),
    .rf_rd(rf_rd), .rf_wr(rf_wr)
  );

  // {addr, rd, wr, priv, dbg, exists, expected illegal}
  localparam int NV = 16;
  localparam logic [18:0] VEC [NV] = '{
    {12'h000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0},  // R1 idle
    {12'hC00, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0},  // R2 read of read-only
    {12'hC00, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1},  // R2 write of read-only
    {12'hF11, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1},  // R2 read+write of read-only
    {12'h100, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1},  // R3 user to supervisor reg
    {12'h100, 1'b1, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0},  // R3 supervisor own level
    {12'h300, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1},  // R3 supervisor to machine reg
    {12'h040, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0},  // R3 machine to user reg
    {12'h200, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1},  // R4 reserved level
    {12'h305, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1},  // R5 missing register
    {12'h7B1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 1'b1},  // R6 debug page outside debug
    {12'h7B2, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0},  // R6 debug page in debug
    {12'h7B0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0},  // R6 debug lifts user priv
    {12'h7A1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0},  // R7 trigger page machine
    {12'h7AF, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1},  // R7 trigger page needs machine
    {12'h000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0}   // R1 idle with missing reg
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      finish_run();
    end
  end

  initial begin
    acc_addr = 12'hC00; acc_wr = 1'b1; cur_priv = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset clears exc_pulse", {31'b0, exc_pulse}, 32'd0);
    @(negedge clk);
    rst = 1'b0; acc_wr = 1'b0; acc_addr = 12'h000;
    #1;
    chk("R1 idle after reset", {31'b0, illegal}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      logic exp_ill;
      v = VEC[i];
      @(negedge clk);
      acc_addr = v[18:7]; acc_rd = v[6]; acc_wr = v[5];
      cur_priv = v[4:3]; dbg_mode = v[2]; csr_exists = v[1];
      exp_ill = v[0];
      #1;
      chk($sformatf("R2-vector %0d illegal (R3 R4 R5 R6 R7)", i), {31'b0, illegal}, {31'b0, exp_ill});
      chk($sformatf("R8 vector %0d rf_rd", i), {31'b0, rf_rd}, {31'b0, v[6] & ~exp_ill});
      chk($sformatf("R8 vector %0d rf_wr", i), {31'b0, rf_wr}, {31'b0, v[5] & ~exp_ill});
      chk($sformatf("R8 vector %0d rf_addr", i), {20'b0, rf_addr}, {20'b0, v[18:7]});
      @(posedge clk); #1;
      chk($sformatf("R9 vector %0d exc_pulse", i), {31'b0, exc_pulse}, {31'b0, exp_ill});
    end

    // R9 single illegal request then idle: exactly one pulse
    @(negedge clk);
    acc_addr = 12'h305; acc_rd = 1'b1; acc_wr = 1'b1; cur_priv = 2'b00;
    dbg_mode = 1'b0; csr_exists = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0; acc_wr = 1'b0;
    chk("R9 pulse after illegal", {31'b0, exc_pulse}, 32'd1);
    @(negedge clk);
    chk("R9 pulse lasts one cycle", {31'b0, exc_pulse}, 32'd0);

    // R9 reset in the cycle after an illegal request suppresses the pulse
    acc_addr = 12'hC01; acc_wr = 1'b1; cur_priv = 2'b11;
    #1;
    chk("R2 write to counter illegal", {31'b0, illegal}, 32'd1);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R9 reset overrides pulse", {31'b0, exc_pulse}, 32'd0);
    @(negedge clk);
    rst = 1'b0; acc_wr = 1'b0;

    // R1 idle with every hazard present
    acc_addr = 12'h7B3; cur_priv = 2'b00; csr_exists = 1'b0;
    #1;
    chk("R1 idle with hazards", {29'b0, illegal, rf_rd, rf_wr}, 32'd0);

    finish_run();
  end
endmodule